// File: doc/BRIEF.md
# Chain-Addressed Microprogram Sequencer with Entry-Code Decoding

This block steps through a fixed microprogram held in an internal control store. The microprogram is split into linear chains: inside a chain the address counter simply counts up. The last word of each chain carries a chain-end flag. At a chain end the next chain is chosen from three condition inputs. The choice uses only the two most-significant address bits, which are enough to tell the chain ends apart because the addresses were placed that way.

The selection logic does not build the next address itself. It produces a 3-bit entry code that names one of five chain entry points. A small lookup decoder turns that code into the 4-bit address to load, and the load happens in the same cycle. One chain is terminal. When its last word is reached, the done output rises and the sequencer freezes until reset.

An external datapath reads the microoperation vector each cycle and feeds back the condition inputs.

Top module: `mpcOutIdController`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted and right after it is released, the address is 0000: microOps reads 0x03 and done reads 0.
- R2: The control store holds these words, given as address → microOps (hex), with chain-end addresses marked *: 0→03, 1*→0C, 2→06, 3→09, 4→10, 5→05, 6*→16, 7→03, 8*→15, 11→0C, 12*→05. Addresses 9, 10 and 13–15 read 00. microOps bit i is microoperation i+1. done is 1 only at address 6.
- R3: On a word that is not a chain end, the next rising edge advances the address by exactly one.
- R4: At a chain end whose major bits are 00 (address 1), the selection logic issues an entry code. The code is 001 when cond[0]=1, 011 when cond[0]=0 and cond[1]=1, and 100 otherwise. The next rising edge therefore loads 2, 7 or 11.
- R5: At a chain end whose major bits are 10 or 11 (addresses 8 and 12), the entry code is 010 when cond[2]=1 and 000 otherwise. The next rising edge therefore loads 5 or 0.
- R6: The entry decoder maps codes 000, 001, 010, 011 and 100 to addresses 0, 2, 5, 7 and 11. The load takes effect at the same edge that would otherwise have incremented the counter, so a chain end is followed directly by the entry word with no extra cycle.
- R7: At the terminal chain end (major bits 01, address 6), done is 1. The address, microOps and done then stay unchanged on every later edge until reset, whatever the conditions are.
- R8: The condition inputs have no effect on a word that is not a chain end.
- R9: The addresses 9, 10, 13, 14 and 15 are never reached from reset under any condition sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the address register updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset to address 0000 |
| cond | input | 3 | Condition inputs; bit 0, bit 1 and bit 2 are the three tested conditions |
| microOps | output | 5 | Microoperation vector of the current word |
| done | output | 1 | High while the terminal chain end is being executed |

## Verification
The assertions assume that cond is known and steady around every rising edge, and that reset is applied from time zero. The bench meets this by changing cond only at falling edges, by holding each value for a whole cycle, and by starting every episode with a reset. The stimulus combines runs that hold each of the eight condition patterns fixed with per-cycle random patterns from a seeded generator. This reaches every transition at each chain end, and it keeps applying conditions inside chains and after termination.

// File: rtl/mpcPkg.sv
`timescale 1ns/1ps
package mpcPkg;
  localparam int ADDR_W    = 4;
  localparam int SEL_W     = 2;
  localparam int CODE_W    = 3;
  localparam int COND_W    = 3;
  localparam int OPS_W     = 5;
  localparam int NUM_ENTRY = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [CODE_W-1:0] code_t;

  // one control-store word
  typedef struct packed {
    logic [OPS_W-1:0] ops;
    logic             chainEnd;
    logic             finish;
  } uword_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic jump;
    logic freeze;
  } strobe_t;

  localparam code_t ENT_START  = 3'd0;
  localparam code_t ENT_BODY   = 3'd1;
  localparam code_t ENT_REJOIN = 3'd2;
  localparam code_t ENT_SIDE   = 3'd3;
  localparam code_t ENT_TAIL   = 3'd4;

  localparam addr_t START_ADDR = 4'd0;

  function automatic addr_t entryAddr(input int idx);
    case (idx)
      0:       return 4'd0;
      1:       return 4'd2;
      2:       return 4'd5;
      3:       return 4'd7;
      4:       return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  function automatic uword_t mkWord(input logic [OPS_W-1:0] ops, input logic e, input logic f);
    uword_t w;
    w.ops      = ops;
    w.chainEnd = e;
    w.finish   = f;
    return w;
  endfunction
endpackage

// File: rtl/mpcCtrlMem.sv
`timescale 1ns/1ps
module mpcCtrlMem
  import mpcPkg::*;
(
  input  addr_t  addr,
  output uword_t word
);
  // placed microprogram; holes at 9, 10 and 13..15 read as empty words
  always_comb begin
    case (addr)
      4'd0:    word = mkWord(5'h03, 1'b0, 1'b0);
      4'd1:    word = mkWord(5'h0C, 1'b1, 1'b0);
      4'd2:    word = mkWord(5'h06, 1'b0, 1'b0);
      4'd3:    word = mkWord(5'h09, 1'b0, 1'b0);
      4'd4:    word = mkWord(5'h10, 1'b0, 1'b0);
      4'd5:    word = mkWord(5'h05, 1'b0, 1'b0);
      4'd6:    word = mkWord(5'h16, 1'b1, 1'b1);
      4'd7:    word = mkWord(5'h03, 1'b0, 1'b0);
      4'd8:    word = mkWord(5'h15, 1'b1, 1'b0);
      4'd11:   word = mkWord(5'h0C, 1'b0, 1'b0);
      4'd12:   word = mkWord(5'h05, 1'b1, 1'b0);
      default: word = mkWord(5'h00, 1'b0, 1'b0);
    endcase
  end
endmodule

// File: rtl/mpcFuncDecoder.sv
`timescale 1ns/1ps
module mpcFuncDecoder
  import mpcPkg::*;
#(
  parameter int NUM_CODES = NUM_ENTRY
)(
  input  code_t code,
  output addr_t target
);
  logic [NUM_CODES-1:0][ADDR_W-1:0] masked;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_ent
    assign masked[i] = (code == CODE_W'(i)) ? entryAddr(i) : '0;
  end

  always_comb begin
    target = '0;
    for (int i = 0; i < NUM_CODES; i++) target = target | masked[i];
  end
endmodule

// File: rtl/mpcControl.sv
`timescale 1ns/1ps
module mpcControl
  import mpcPkg::*;
(
  input  logic              chainEnd,
  input  sel_t              majorBits,
  input  logic [COND_W-1:0] cond,
  output strobe_t           strb,
  output code_t             entryCode
);
  // only the major address bits identify which chain end is active
  always_comb begin
    strb      = '0;
    entryCode = ENT_START;
    if (!chainEnd) begin
      strb.advance = 1'b1;
    end else begin
      case (majorBits)
        2'b00: begin
          strb.jump = 1'b1;
          if (cond[0])      entryCode = ENT_BODY;
          else if (cond[1]) entryCode = ENT_SIDE;
          else              entryCode = ENT_TAIL;
        end
        2'b01: strb.freeze = 1'b1;
        default: begin
          strb.jump = 1'b1;
          entryCode = cond[2] ? ENT_REJOIN : ENT_START;
        end
      endcase
    end
  end
endmodule

// File: rtl/mpcDatapath.sv
`timescale 1ns/1ps
module mpcDatapath
  import mpcPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  code_t   entryCode,
  output addr_t   addr,
  output uword_t  word
);
  addr_t loadAddr;

  mpcFuncDecoder u_dec (.code(entryCode), .target(loadAddr));
  mpcCtrlMem     u_mem (.addr(addr), .word(word));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addr <= START_ADDR;
    else if (strb.jump)    addr <= loadAddr;
    else if (strb.advance) addr <= addr + 1'b1;
  end

  // R3: inside a chain the counter steps by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    !word.chainEnd |=> addr == $past(addr) + 4'd1);

  // R7: terminal word holds the sequencer still
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    word.finish |=> word.finish && $stable(addr) && $stable(word.ops));

  // R6: a non-terminal chain end lands on an entry point
  a_r6_entry_land: assert property (@(posedge clk) disable iff (!rstN)
    (word.chainEnd && !word.finish) |=>
      (addr == 4'd0 || addr == 4'd2 || addr == 4'd5 || addr == 4'd7 || addr == 4'd11));

  // R9: holes in the address space are never visited
  a_r9_no_hole: assert property (@(posedge clk) disable iff (!rstN)
    !(addr == 4'd9 || addr == 4'd10 || addr > 4'd12));
endmodule

// File: rtl/mpcOutIdController.sv
`timescale 1ns/1ps
module mpcOutIdController
  import mpcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [COND_W-1:0] cond,
  output logic [OPS_W-1:0]  microOps,
  output logic              done
);
  strobe_t strb;
  code_t   entryCode;
  addr_t   addr;
  uword_t  word;

  mpcControl u_ctl (
    .chainEnd (word.chainEnd),
    .majorBits(addr[ADDR_W-1 -: SEL_W]),
    .cond     (cond),
    .strb     (strb),
    .entryCode(entryCode)
  );

  mpcDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .entryCode(entryCode),
    .addr     (addr),
    .word     (word)
  );

  assign microOps = word.ops;
  assign done     = word.finish;

  // R5: upper chain ends rejoin at address 5 when cond[2] is set
  a_r5_rejoin: assert property (@(posedge clk) disable iff (!rstN)
    (word.chainEnd && addr[3] && cond[2]) |=> addr == 4'd5);

  // R4: first chain end with cond[0] enters the long chain at 2
  a_r4_body: assert property (@(posedge clk) disable iff (!rstN)
    (word.chainEnd && addr[3:2] == 2'b00 && cond[0]) |=> addr == 4'd2);
endmodule

// File: tb/test_mpcOutIdController.sv
`timescale 1ns/1ps
module test_mpcOutIdController;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cond = 3'd0;
  logic [4:0] microOps;
  logic       done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  mpcOutIdController i_mpcOutIdController (
    .clk(clk), .rstN(rstN), .cond(cond), .microOps(microOps), .done(done)
  );

  always #2.5 clk = ~clk;

  // expected word contents (R2)
  function automatic logic [4:0] expOps(input logic [3:0] a);
    case (a)
      4'd0: return 5'h03;  4'd1: return 5'h0C;  4'd2: return 5'h06;
      4'd3: return 5'h09;  4'd4: return 5'h10;  4'd5: return 5'h05;
      4'd6: return 5'h16;  4'd7: return 5'h03;  4'd8: return 5'h15;
      4'd11: return 5'h0C; 4'd12: return 5'h05;
      default: return 5'h00;
    endcase
  endfunction

  function automatic bit expEnd(input logic [3:0] a);
    return (a == 4'd1 || a == 4'd6 || a == 4'd8 || a == 4'd12);
  endfunction

  function automatic logic [3:0] nextAddr(input logic [3:0] a, input logic [2:0] x);
    if (!expEnd(a)) return a + 4'd1;
    if (a == 4'd6) return a;
    if (a == 4'd1) return x[0] ? 4'd2 : (x[1] ? 4'd7 : 4'd11);
    return x[2] ? 4'd5 : 4'd0;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cond = 3'($urandom);
    repeat (2) @(negedge clk);
    #1;
    check("R1 microOps in reset", microOps, 5'h03);
    check("R1 done in reset", done, 0);
    rstN = 1'b1;
    #1;
    check("R1 microOps after release", microOps, 5'h03);
    check("R1 done after release", done, 0);
  endtask

  task automatic runEpisode(input int fixedX, input int maxCycles);
    logic [3:0] model = 4'd0;
    int afterFin = 0;
    doReset();
    for (int c = 0; c < maxCycles; c++) begin
      logic [2:0] x;
      string tag;
      x = (fixedX < 0) ? 3'($urandom) : 3'(fixedX);
      cond = x;
      if (model == 4'd6)       tag = "R7";
      else if (model == 4'd1)  tag = "R4/R6";
      else if (expEnd(model))  tag = "R5/R6";
      else                     tag = "R3/R8";
      model = nextAddr(model, x);
      @(negedge clk);
      #1;
      // word contents, and no visit to a hole (R2/R9)
      check({tag, " R2/R9 microOps"}, microOps, expOps(model));
      check({tag, " done"}, done, (model == 4'd6) ? 1 : 0);
      if (model == 4'd6) begin
        afterFin++;
        if (afterFin > 3) break;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed: each condition pattern held for a full run
    for (int x = 0; x < 8; x++) runEpisode(x, 40);
    // random per-cycle conditions
    for (int e = 0; e < 300; e++) runEpisode(-1, 30);
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule